// File: doc/BRIEF.md
# Bus-Programmable Up/Down Event Timer

This block is an 8-bit counter that runs on the system clock and advances on rising edges of one of sixteen slow tick inputs. Software reaches it through a small register bank on a strobed bus whose select, read and write strobes are active low. Through that bank, software picks the tick source, turns each output on or off, stops or runs the count, loads the count, and reads or clears two sticky wrap flags. A separate input sets the direction. A step from 0xFF to 0x00 while counting up raises the overflow flag. A step from 0x00 to 0xFF while counting down raises the underflow flag.

Each tick input is treated as a level. It passes through a two-flop synchronizer and a rising-edge detector in the system clock domain. There are three outputs. Two interrupt lines each follow one sticky flag, gated by its enable. A pulse line goes high for one cycle on every wrap while it is enabled.

Top module: `updown_timer`

## Requirements
- R1: While rst_n is low at a clock edge, the control, count and flag state all clear to zero. All three outputs then read low.
- R2: A write with bus_sel_n and bus_wr_n low stores bus_wdata[7:0] into the register chosen by bus_addr: 0 selects control, 1 selects count, 2 selects flags. While bus_sel_n and bus_rd_n are low, bus_rdata returns that register zero-extended to 16 bits. Address 3 and bus_rdata[15:8] always read as zero.
- R3: A write to address 1 replaces the live count from the next cycle on. A read of address 1 returns the live count.
- R4: Control bits [3:0] pick which tick input advances the count. The count steps once, at the third clock edge after the selected input rises. Edges on inputs that are not selected have no effect.
- R5: With count_down low, a step from 0xFF wraps to 0x00 and sets flag bit 7.
- R6: While control bit 7 is 1, ticks leave the count unchanged.
- R7: With count_down high, a step from 0x00 wraps to 0xFF and sets flag bit 6.
- R8: A flag bit clears only when a write to address 2 carries 0 in that bit position. Writing 1 leaves the bit as it is. If a wrap and a clearing write land in the same cycle, the flag stays set.
- R9: irq_over is flag bit 7 gated by control bit 4. irq_under is flag bit 6 gated by control bit 5.
- R10: When control bit 6 is set, evt_pulse is high for exactly the one cycle after each wrap. It stays low on steps that do not wrap.
- R11: A count write that lands in the same cycle as a tick wins: the written value is kept and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_src | input | 16 | Tick source levels |
| count_down | input | 1 | 1 counts down, 0 counts up |
| bus_sel_n | input | 1 | Bus select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data, low byte used |
| bus_rdata | output | 16 | Read data |
| irq_over | output | 1 | Overflow interrupt |
| irq_under | output | 1 | Underflow interrupt |
| evt_pulse | output | 1 | One-cycle wrap pulse |

## Verification
The counting path is driven in several ways:
- Edges arrive on the selected input and on a different input. Comparing the two shows that tick selection really works.
- Steps are made in both directions, both away from the boundaries and across them. This separates plain stepping from the wrap behaviour that sets the flags and the pulse.
- A stopped run shows that the run/stop bit gates stepping.
- A count write is timed to land in the same cycle as a tick. The final count then shows which of the two has priority.
- Flag writes carrying 0 and carrying 1 in each bit position separate clearing from holding.

// File: rtl/updown_timer_pkg.sv
package updown_timer_pkg;
    localparam int DW   = 8;
    localparam int BW   = 16;
    localparam int AW   = 2;
    localparam int NSRC = 16;
    localparam int SELW = $clog2(NSRC);

    typedef enum logic [AW-1:0] {
        ADDR_CTRL  = 2'b00,
        ADDR_COUNT = 2'b01,
        ADDR_FLAGS = 2'b10,
        ADDR_RSVD  = 2'b11
    } reg_addr_e;

    typedef struct packed {
        logic            stop;
        logic            pulse_en;
        logic            under_en;
        logic            over_en;
        logic [SELW-1:0] src_sel;
    } ctrl_t;

    typedef struct packed {
        logic over;
        logic under;
    } flags_t;

    function automatic logic [BW-1:0] widen(input logic [DW-1:0] v);
        return {{(BW-DW){1'b0}}, v};
    endfunction
endpackage

// File: rtl/ut_tick_detect.sv
module ut_tick_detect #(
    parameter int NSRC = 16,
    parameter int SELW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    input  logic [SELW-1:0] sel,
    output logic            tick
);
    logic [NSRC-1:0] rise;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic [2:0] sh;
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[1:0], src[g]};
        end
        assign rise[g] = sh[1] & ~sh[2];
    end

    assign tick = rise[sel];
endmodule

// File: rtl/ut_counter.sv
module ut_counter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [DW-1:0] load_val,
    input  logic          step,
    input  logic          down,
    output logic [DW-1:0] count,
    output logic          over_evt,
    output logic          under_evt
);
    always_comb begin
        over_evt  = step & ~load_en & ~down & (count == '1);
        under_evt = step & ~load_en &  down & (count == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (load_en) count <= load_val;
        else if (step)    count <= down ? count - 1'b1 : count + 1'b1;
    end
endmodule

// File: rtl/ut_regs.sv
module ut_regs
    import updown_timer_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] wdata,
    input  logic [DW-1:0] count,
    input  logic          over_evt,
    input  logic          under_evt,
    output ctrl_t         ctrl_q,
    output flags_t        flags_q,
    output logic          load_en,
    output logic [DW-1:0] load_val,
    output logic [BW-1:0] rdata
);
    reg_addr_e ra;
    logic      wr_hit, rd_hit, clr_over, clr_under;

    always_comb begin
        ra        = reg_addr_e'(addr);
        wr_hit    = ~sel_n & ~wr_n;
        rd_hit    = ~sel_n & ~rd_n;
        load_en   = wr_hit & (ra == ADDR_COUNT);
        load_val  = wdata[DW-1:0];
        clr_over  = wr_hit & (ra == ADDR_FLAGS) & ~wdata[DW-1];
        clr_under = wr_hit & (ra == ADDR_FLAGS) & ~wdata[DW-2];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            flags_q <= '0;
        end else begin
            if (wr_hit && ra == ADDR_CTRL) ctrl_q <= ctrl_t'(wdata[DW-1:0]);
            flags_q.over  <= over_evt  | (flags_q.over  & ~clr_over);
            flags_q.under <= under_evt | (flags_q.under & ~clr_under);
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            unique case (ra)
                ADDR_CTRL:  rdata = widen(ctrl_q);
                ADDR_COUNT: rdata = widen(count);
                ADDR_FLAGS: rdata = widen({flags_q.over, flags_q.under, {(DW-2){1'b0}}});
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/updown_timer.sv
module updown_timer
    import updown_timer_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] tick_src,
    input  logic            count_down,
    input  logic            bus_sel_n,
    input  logic            bus_rd_n,
    input  logic            bus_wr_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic [BW-1:0]   bus_wdata,
    output logic [BW-1:0]   bus_rdata,
    output logic            irq_over,
    output logic            irq_under,
    output logic            evt_pulse
);
    ctrl_t         ctrl_q;
    flags_t        flags_q;
    logic          tick, step, load_en, over_evt, under_evt, pulse_q;
    logic [DW-1:0] load_val, count;

    ut_tick_detect #(.NSRC(NSRC), .SELW(SELW)) u_tick (
        .clk(clk), .rst_n(rst_n), .src(tick_src), .sel(ctrl_q.src_sel), .tick(tick)
    );

    assign step = tick & ~ctrl_q.stop;

    ut_counter #(.DW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
        .step(step), .down(count_down), .count(count),
        .over_evt(over_evt), .under_evt(under_evt)
    );

    ut_regs u_regs (
        .clk(clk), .rst_n(rst_n), .sel_n(bus_sel_n), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
        .addr(bus_addr), .wdata(bus_wdata), .count(count), .over_evt(over_evt),
        .under_evt(under_evt), .ctrl_q(ctrl_q), .flags_q(flags_q), .load_en(load_en),
        .load_val(load_val), .rdata(bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= (over_evt | under_evt) & ctrl_q.pulse_en;
    end

    assign irq_over  = flags_q.over  & ctrl_q.over_en;
    assign irq_under = flags_q.under & ctrl_q.under_en;
    assign evt_pulse = pulse_q;
endmodule

// File: rtl/updown_timer_chk.sv
module updown_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  ctrl,
    input logic [1:0]  flags,
    input logic [7:0]  count,
    input logic        load_en,
    input logic        under_evt,
    input logic        bus_sel_n,
    input logic        bus_wr_n,
    input logic [1:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic        irq_over,
    input logic        irq_under,
    input logic        evt_pulse
);
    logic clr_over_wr;
    assign clr_over_wr = !bus_sel_n && !bus_wr_n && bus_addr == 2'b10 && !bus_wdata[7];

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (count == 8'h00 && flags == 2'b00 && ctrl == 8'h00));

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[15:8] == 8'h00);

    assert_load_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> count == $past(bus_wdata[7:0]));

    assert_stop_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[7] && !load_en) |=> $stable(count));

    assert_over_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !clr_over_wr) |=> flags[1]);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        under_evt |=> flags[0]);

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_over |-> (ctrl[4] && flags[1])) and (irq_under |-> (ctrl[5] && flags[0])));

    assert_pulse_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |-> $past(ctrl[6]));
endmodule

bind updown_timer updown_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .flags(flags_q), .count(count),
    .load_en(load_en), .under_evt(under_evt), .bus_sel_n(bus_sel_n),
    .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_over(irq_over), .irq_under(irq_under),
    .evt_pulse(evt_pulse)
);

// File: tb/updown_timer_tb.sv
`timescale 1ns/1ps
module updown_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tick_src = '0;
    logic        count_down = 1'b0;
    logic        bus_sel_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_over, irq_under, evt_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    event        rd_ev;

    always #2.5 clk = ~clk;

    updown_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .count_down(count_down),
        .bus_sel_n(bus_sel_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_over(irq_over), .irq_under(irq_under), .evt_pulse(evt_pulse)
    );

    task automatic chk(input string t, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", t, act, exp);
        end
    endtask

    // monitor: pops the expected read value and compares it with the bus
    always @(rd_ev) begin
        if (exp_q.size() == 0) begin
            chk("scoreboard underrun", 16'h0, 16'h1);
        end else begin
            chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel_n = 1'b0; bus_wr_n = 1'b0; bus_addr = a; bus_wdata = {8'h00, d};
        @(negedge clk);
        bus_sel_n = 1'b1; bus_wr_n = 1'b1;
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_sel_n = 1'b0; bus_rd_n = 1'b0; bus_addr = a;
        #1 -> rd_ev;
        @(posedge clk);
        #1 bus_sel_n = 1'b1; bus_rd_n = 1'b1;
    endtask

    // one rising edge on source i; the step lands at the third edge,
    // pulse_seen is sampled in the cycle right after it
    task automatic tick(input int i, output logic pulse_seen);
        @(negedge clk);
        tick_src[i] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        tick_src[i] = 1'b0;
        @(negedge clk);
        pulse_seen = evt_pulse;
        @(negedge clk);
    endtask

    initial begin
        logic p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq_over", {15'h0, irq_over}, 16'h0);
        chk("R1 irq_under", {15'h0, irq_under}, 16'h0);
        chk("R1 evt_pulse", {15'h0, evt_pulse}, 16'h0);
        rd(2'd0, 16'h0000, "R1 ctrl");
        rd(2'd1, 16'h0000, "R1 count");
        rd(2'd2, 16'h0000, "R1 flags");
        // R2 map
        wr(2'd0, 8'h73);
        rd(2'd0, 16'h0073, "R2 ctrl readback");
        rd(2'd3, 16'h0000, "R2 reserved");
        // R3 load
        wr(2'd1, 8'hFE);
        rd(2'd1, 16'h00FE, "R3 load");
        // R4 selection
        tick(5, p);
        rd(2'd1, 16'h00FE, "R4 unselected source");
        tick(3, p);
        rd(2'd1, 16'h00FF, "R4 selected step");
        chk("R10 no pulse without wrap", {15'h0, p}, 16'h0);
        // R5 overflow
        tick(3, p);
        rd(2'd1, 16'h0000, "R5 wrap to zero");
        rd(2'd2, 16'h0080, "R5 over flag");
        chk("R10 wrap pulse", {15'h0, p}, 16'h1);
        chk("R10 pulse one cycle", {15'h0, evt_pulse}, 16'h0);
        chk("R9 irq_over", {15'h0, irq_over}, 16'h1);
        chk("R9 irq_under idle", {15'h0, irq_under}, 16'h0);
        // R6 stop
        wr(2'd0, 8'hF3);
        tick(3, p);
        rd(2'd1, 16'h0000, "R6 stopped");
        // R7 underflow
        wr(2'd0, 8'h73);
        count_down = 1'b1;
        tick(3, p);
        rd(2'd1, 16'h00FF, "R7 wrap to FF");
        rd(2'd2, 16'h00C0, "R7 under flag");
        chk("R9 irq_under", {15'h0, irq_under}, 16'h1);
        // R8 clearing
        wr(2'd2, 8'h40);
        rd(2'd2, 16'h0040, "R8 clear over keep under");
        wr(2'd2, 8'hFF);
        rd(2'd2, 16'h0040, "R8 write one holds");
        // R9 gating
        wr(2'd0, 8'h03);
        chk("R9 gated under", {15'h0, irq_under}, 16'h0);
        wr(2'd0, 8'h23);
        chk("R9 regated under", {15'h0, irq_under}, 16'h1);
        wr(2'd2, 8'h00);
        rd(2'd2, 16'h0000, "R8 clear under");
        // R11 load beats tick in the same cycle
        count_down = 1'b0;
        wr(2'd1, 8'h10);
        @(negedge clk);
        tick_src[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_sel_n = 1'b0; bus_wr_n = 1'b0; bus_addr = 2'd1; bus_wdata = 16'h0055;
        @(negedge clk);
        bus_sel_n = 1'b1; bus_wr_n = 1'b1; tick_src[3] = 1'b0;
        repeat (3) @(negedge clk);
        rd(2'd1, 16'h0055, "R11 load priority");
        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) chk("scoreboard leftover", 16'h1, 16'h0);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule